// File: doc/BRIEF.md
# Register-File ALU Datapath

This block is the execution core of a small processor. Seven general registers feed two source selectors. The selectors drive an A operand and a B operand into one arithmetic/logic unit. A 14-bit control word arrives every clock. It names both sources, the operation, and the one register that captures the result. Either source can take the external data input in place of a register.

The ALU result is always driven on the result output. A nonzero destination code loads it into one register on the next rising edge. Destination code zero leaves every register untouched, so the block can act as a pure calculator on external data. Zero, carry and sign flags follow the current operation combinationally.

Top module: `regalu_datapath`

## Requirements
- R1: The control word fields are: bits [13:11] A source, bits [10:8] B source, bits [7:5] destination, bits [4:0] operation code.
- R2: Source code 000 routes `ext_in` onto that operand. Codes 001 to 111 route the register with that number.
- R3: Operation codes: 00000 A; 00001 A+1; 00010 A+B; 00101 A−B; 00110 A−1; 01000 A AND B; 01010 A OR B; 01100 A XOR B; 01110 NOT A; 10000 A logical right shift by one; 11000 A left shift by one. Arithmetic wraps modulo 2^WIDTH.
- R4: Destination code 000 loads no register, while `result` still shows the ALU output in that cycle.
- R5: A nonzero destination code loads exactly that register with the cycle's result at the rising edge. All other registers keep their values.
- R6: A register used as both source and destination supplies its old value during the cycle. It holds the new value afterwards.
- R7: A synchronous active-high `rst` clears all seven registers to zero.
- R8: `flag_zero` is 1 when the result is zero. `flag_sign` is the result's top bit. `flag_carry` depends on the operation:
  - the carry out for add and increment;
  - the borrow (A below the subtrahend) for subtract and decrement;
  - the bit shifted out for the shifts;
  - 0 for all other operations.
- R9: Any operation code not listed in R3 gives result zero and carry 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 14 | Per-cycle control word |
| ext_in | input | WIDTH | External operand |
| result | output | WIDTH | ALU output |
| flag_zero | output | 1 | Result equals zero |
| flag_carry | output | 1 | Carry, borrow or shifted-out bit |
| flag_sign | output | 1 | Most significant result bit |

## Verification
The bench goes after the following corner cases:
- **Same register as source and destination.** A design that forwarded the new value would show the sum twice over.
- **Destination code zero.** A design that decoded this code as a register would corrupt a stored value, and a later read would show it.
- **Wrapping sums and borrows.** A design that mishandled the extra result bit would report wrong carry flags.
- **Unlisted operation codes.** A design that fell through to another operation would show a nonzero result.
- **Mid-run reset.** A reset that missed a register would leave a stale value visible on readback.

// File: rtl/regalu_pkg.sv
package regalu_pkg;

    localparam int unsigned NUM_REGS = 7;
    localparam int unsigned SEL_W    = 3;
    localparam int unsigned OP_W     = 5;
    localparam int unsigned CTRL_W   = 3 * SEL_W + OP_W;

    typedef enum logic [OP_W-1:0] {
        OP_PASS = 5'b00000,
        OP_INC  = 5'b00001,
        OP_ADD  = 5'b00010,
        OP_SUB  = 5'b00101,
        OP_DEC  = 5'b00110,
        OP_AND  = 5'b01000,
        OP_OR   = 5'b01010,
        OP_XOR  = 5'b01100,
        OP_NOT  = 5'b01110,
        OP_SHR  = 5'b10000,
        OP_SHL  = 5'b11000
    } alu_op_e;

    typedef struct packed {
        logic [SEL_W-1:0] src_a;
        logic [SEL_W-1:0] src_b;
        logic [SEL_W-1:0] dest;
        logic [OP_W-1:0]  op;
    } ctrl_t;

    typedef struct packed {
        logic zero;
        logic carry;
        logic sign;
    } flags_t;

    function automatic ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] raw);
        return ctrl_t'(raw);
    endfunction

endpackage

// File: rtl/regalu_dest_dec.sv
module regalu_dest_dec
    import regalu_pkg::*;
(
    input  logic [SEL_W-1:0]   dest,
    output logic [NUM_REGS:1]  load_en
);
    for (genvar i = 1; i <= NUM_REGS; i++) begin : g_dec
        assign load_en[i] = (dest == SEL_W'(i));
    end
endmodule

// File: rtl/regalu_regfile.sv
module regalu_regfile
    import regalu_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_REGS:1]    load_en,
    input  logic [WIDTH-1:0]     wr_data,
    input  logic [SEL_W-1:0]     src_a,
    input  logic [SEL_W-1:0]     src_b,
    input  logic [WIDTH-1:0]     ext_in,
    output logic [WIDTH-1:0]     a_bus,
    output logic [WIDTH-1:0]     b_bus
);
    logic [NUM_REGS:1][WIDTH-1:0] regs_q;

    for (genvar i = 1; i <= NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[i] <= '0;
            else if (load_en[i])
                regs_q[i] <= wr_data;
        end

        // R5
        reg_load_chk: assert property (@(posedge clk) disable iff (rst)
            load_en[i] |=> regs_q[i] == $past(wr_data));
        // R5
        reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !load_en[i] |=> $stable(regs_q[i]));
    end

    always_comb begin
        a_bus = (src_a == '0) ? ext_in : regs_q[src_a];
        b_bus = (src_b == '0) ? ext_in : regs_q[src_b];
    end

    // R7
    reg_reset_chk: assert property (@(posedge clk)
        rst |=> regs_q == '0);

    // R4
    no_dest_chk: assert property (@(posedge clk) disable iff (rst)
        (load_en == '0) |=> $stable(regs_q));
endmodule

// File: rtl/regalu_alu.sv
module regalu_alu
    import regalu_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [OP_W-1:0]  op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y,
    output flags_t           flags
);
    localparam int unsigned EXT_W = WIDTH + 1;

    logic [EXT_W-1:0] wide;
    logic [WIDTH-1:0] one;

    assign one = WIDTH'(1);

    always_comb begin
        case (alu_op_e'(op))
            OP_PASS: wide = {1'b0, a};
            OP_INC:  wide = {1'b0, a} + {1'b0, one};
            OP_ADD:  wide = {1'b0, a} + {1'b0, b};
            OP_SUB:  wide = {1'b0, a} - {1'b0, b};
            OP_DEC:  wide = {1'b0, a} - {1'b0, one};
            OP_AND:  wide = {1'b0, a & b};
            OP_OR:   wide = {1'b0, a | b};
            OP_XOR:  wide = {1'b0, a ^ b};
            OP_NOT:  wide = {1'b0, ~a};
            OP_SHR:  wide = {a[0], 1'b0, a[WIDTH-1:1]};
            OP_SHL:  wide = {a, 1'b0};
            default: wide = '0;
        endcase
        y           = wide[WIDTH-1:0];
        flags.carry = wide[WIDTH];
        flags.zero  = (wide[WIDTH-1:0] == '0);
        flags.sign  = wide[WIDTH-1];
    end
endmodule

// File: rtl/regalu_datapath.sv
module regalu_datapath
    import regalu_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [13:0]       ctrl_word,
    input  logic [WIDTH-1:0]  ext_in,
    output logic [WIDTH-1:0]  result,
    output logic              flag_zero,
    output logic              flag_carry,
    output logic              flag_sign
);
    ctrl_t               cw;
    logic [NUM_REGS:1]   load_en;
    logic [WIDTH-1:0]    a_bus;
    logic [WIDTH-1:0]    b_bus;
    logic [WIDTH-1:0]    alu_y;
    flags_t              alu_flags;

    assign cw = unpack_ctrl(ctrl_word);

    regalu_dest_dec u_dec (
        .dest    (cw.dest),
        .load_en (load_en)
    );

    regalu_regfile #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .load_en (load_en),
        .wr_data (alu_y),
        .src_a   (cw.src_a),
        .src_b   (cw.src_b),
        .ext_in  (ext_in),
        .a_bus   (a_bus),
        .b_bus   (b_bus)
    );

    regalu_alu #(.WIDTH(WIDTH)) u_alu (
        .op    (cw.op),
        .a     (a_bus),
        .b     (b_bus),
        .y     (alu_y),
        .flags (alu_flags)
    );

    assign result     = alu_y;
    assign flag_zero  = alu_flags.zero;
    assign flag_carry = alu_flags.carry;
    assign flag_sign  = alu_flags.sign;

    // R2
    ext_route_chk: assert property (@(posedge clk) disable iff (rst)
        (cw.src_a == '0) |-> a_bus == ext_in);
    // R3
    sub_relation_chk: assert property (@(posedge clk) disable iff (rst)
        (cw.op == OP_SUB) |-> WIDTH'(result + b_bus) == a_bus);
    // R8
    add_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (cw.op == OP_ADD) |-> flag_carry == (result < a_bus));
    // R8
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        flag_zero |-> result == '0);
endmodule

// File: tb/regalu_datapath_bench.sv
module regalu_datapath_bench;
    localparam int W = 8;
    localparam int NV = 19;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [13:0]  ctrl_word = '0;
    logic [W-1:0] ext_in = '0;
    logic [W-1:0] result;
    logic         flag_zero, flag_carry, flag_sign;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    regalu_datapath #(.WIDTH(W)) u_regalu_datapath (
        .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .ext_in(ext_in),
        .result(result), .flag_zero(flag_zero),
        .flag_carry(flag_carry), .flag_sign(flag_sign)
    );

    // {ctrl: srcA srcB dest op, ext_in, expected result, expected zero/carry/sign}
    localparam logic [32:0] VEC [NV] = '{
        {14'b000_000_010_00000, 8'h25, 8'h25, 3'b000}, // R2 R5 load R2
        {14'b000_000_011_00000, 8'h13, 8'h13, 3'b000}, // R2 R5 load R3
        {14'b010_011_001_00101, 8'h00, 8'h12, 3'b000}, // R1 R3 R1<=R2-R3
        {14'b001_010_000_00010, 8'h00, 8'h37, 3'b000}, // R3 add, R4 no write
        {14'b001_000_000_00101, 8'h40, 8'hD2, 3'b011}, // R8 borrow
        {14'b000_000_100_00001, 8'hFF, 8'h00, 3'b110}, // R3 R8 inc wraps
        {14'b100_000_101_00110, 8'h00, 8'hFF, 3'b011}, // R3 R8 dec borrow
        {14'b101_010_000_01000, 8'h00, 8'h25, 3'b000}, // R3 and
        {14'b010_011_000_01010, 8'h00, 8'h37, 3'b000}, // R3 or
        {14'b010_011_000_01100, 8'h00, 8'h36, 3'b000}, // R3 xor
        {14'b010_000_000_01110, 8'h00, 8'hDA, 3'b001}, // R3 not
        {14'b000_000_110_10000, 8'h81, 8'h40, 3'b010}, // R3 R8 shr out bit
        {14'b000_000_111_11000, 8'h81, 8'h02, 3'b010}, // R3 R8 shl out bit
        {14'b110_111_110_00010, 8'h00, 8'h42, 3'b000}, // R6 R6<=R6+R7
        {14'b110_000_000_00000, 8'h00, 8'h42, 3'b000}, // R6 new value held
        {14'b000_000_000_00011, 8'h55, 8'h00, 3'b100}, // R9 unlisted op
        {14'b000_000_000_00010, 8'h80, 8'h00, 3'b110}, // R8 add wraps
        {14'b111_000_000_00000, 8'h00, 8'h02, 3'b000}, // R5 R7 kept
        {14'b001_000_000_00101, 8'h12, 8'h00, 3'b100}  // R1 R8 equal sub
    };

    task automatic check(input string tag, input logic [W-1:0] exp_r,
                         input logic [2:0] exp_f);
        checks++;
        if (result !== exp_r || {flag_zero, flag_carry, flag_sign} !== exp_f) begin
            failures++;
            $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
                     tag, result, {flag_zero, flag_carry, flag_sign}, exp_r, exp_f);
        end
    endtask

    task automatic drive(input logic [13:0] cw, input logic [W-1:0] ex);
        @(negedge clk);
        ctrl_word = cw;
        ext_in = ex;
        #5;
    endtask

    initial begin
        #400000;
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R7 reset state: R1 reads zero
        drive(14'b001_000_000_00000, 8'h00);
        check("R7 reset state", 8'h00, 3'b100);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][32:19], VEC[i][18:11]);
            check($sformatf("vector %0d", i), VEC[i][10:3], VEC[i][2:0]);
        end

        // R4: destination 000 leaves R2 unchanged
        drive(14'b000_000_010_00000, 8'h77);
        drive(14'b000_000_000_00000, 8'h99);
        check("R4 result visible", 8'h99, 3'b001);
        drive(14'b010_000_000_00000, 8'h00);
        check("R4 R2 kept", 8'h77, 3'b000);

        // R7: mid-run reset clears all registers
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int r = 1; r <= 7; r++) begin
            drive({3'(r), 3'b000, 3'b000, 5'b00000}, 8'hAA);
            check($sformatf("R7 reg %0d cleared", r), 8'h00, 3'b100);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule